// File: doc/BRIEF.md
# Mixed-Kind Stallable Pipeline Controller

This block is a linear pipeline of `NUM_STAGES` stages. It carries a data word and a valid flag from a `go` strobe to a result port. Each stage is given one of four kinds at compile time: continuous, non-stallable, stallable or runoff. The kind decides how that stage's valid is formed and when its enable register and data register update. A single global `stall` input freezes the stallable stages. Runoff stages keep draining during a stall whenever a drain permit travels with their token. That permit is raised by a non-stallable stage and handed on from runoff stage to runoff stage.

Each stage applies a fixed placeholder operation to the word: stage `i` adds the constant `i+1`. Stages `0` to `NUM_STAGES-2` end in a data register. The last stage drives the result port combinationally. Stage `0` is enabled by `go` directly. A token therefore appears at the output `NUM_STAGES-1` cycles after its `go` when nothing stalls it. There is no backpressure: a `go` that a stalled stage 0 cannot accept is lost.

Top module: `pl_mixed_pipe`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable register, permit register and data register clears to 0. After reset, with `go` low, `out_valid` stays 0.
- R2: The kind of stage `i` is the 2-bit field `STAGE_KINDS[2i+1:2i]`, with 0 = continuous, 1 = non-stallable, 2 = stallable and 3 = runoff. Stage 0's enable is `go` itself. Every later stage has a one-bit enable register that captures the previous stage's valid.
- R3: `data_out` equals the input word of the token plus the sum of `i+1` over all stages, modulo 2^`DATA_W`. With no stall, it appears `NUM_STAGES-1` cycles after the `go` cycle.
- R4: A stallable stage's valid is its enable AND NOT `stall`. While `stall` is high, its enable register and its data register hold their values.
- R5: A non-stallable stage's valid equals its enable whatever `stall` is. Its enable register captures the previous valid on every clock.
- R6: A runoff stage's valid is its enable AND (its permit OR NOT `stall`). A non-stallable stage issues its own valid as the permit. A runoff stage passes on the permit it received. All other kinds issue 0. The permit register of a stage captures the upstream permit on every clock.
- R7: A runoff stage's enable register updates when `stall` is low, when the upstream permit is high, or when the stage itself was valid that cycle. A token that drained during a stall is therefore never issued twice.
- R8: If any stage is not continuous, a stage's data register loads only in a cycle where that stage is valid. If all stages are continuous, the data registers load on every clock.
- R9: `out_valid` is the valid of the last stage. It therefore follows `stall` in the same cycle when the last stage is stallable or runoff.
- R10: When stage 0 is stallable, a `go` raised while `stall` is high produces no token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start strobe; enable of stage 0 |
| stall | input | 1 | Global stall, freezes stallable stages |
| data_in | input | DATA_W | Word entering stage 0 |
| data_out | output | DATA_W | Result word of the last stage |
| out_valid | output | 1 | Valid of the last stage |

## Verification
The bench runs two configurations side by side. The first mixes kinds as stallable, stallable, non-stallable, runoff, runoff. The second is fully continuous. A single `go` pulse with no stall shows the latency and the added constants. A burst followed by a long stall separates the stages that freeze from the runoff stages that keep shifting under the permit. That same stall window, held through a further `go`, shows whether a stalled-off token is dropped and whether a drained token is issued twice once the stall lifts. A stall that toggles every cycle tests the non-stallable capture. Long seeded random runs, with sparse and with bursty stalls, compare every cycle's valid and data against a bench-side model. In the continuous copy, data is compared even when it is not valid, which checks that its data registers load on every clock.

// File: rtl/pl_pkg.sv
// Package: stage kinds and the per-kind valid and permit rules shared by
// the pipeline stages. Assumes at most MAX_STAGES stages, 2 bits per kind.
package pl_pkg;

    localparam int MAX_STAGES = 8;
    localparam int KIND_W     = 2;
    localparam int KVEC_W     = MAX_STAGES * KIND_W;

    typedef enum logic [KIND_W-1:0] {
        KIND_CONT    = 2'd0,
        KIND_NOSTALL = 2'd1,
        KIND_STALL   = 2'd2,
        KIND_RUNOFF  = 2'd3
    } stage_kind_e;

    // Extract the kind of stage idx from the packed kind vector.
    function automatic stage_kind_e kind_at(logic [KVEC_W-1:0] kvec, int idx);
        return stage_kind_e'(kvec[KIND_W*idx +: KIND_W]);
    endfunction

    // True when the first n stages are all continuous.
    function automatic bit all_continuous(logic [KVEC_W-1:0] kvec, int n);
        bit r;
        r = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (kind_at(kvec, k) != KIND_CONT) r = 1'b0;
        end
        return r;
    endfunction

    // Valid of a stage, given its kind, enable, held permit and stall.
    function automatic logic kind_valid(stage_kind_e kind, logic en,
                                        logic permit, logic stall);
        logic v;
        case (kind)
            KIND_STALL:  v = en & ~stall;
            KIND_RUNOFF: v = en & (permit | ~stall);
            default:     v = en;
        endcase
        return v;
    endfunction

    // Permit a stage hands downstream.
    function automatic logic kind_permit_out(stage_kind_e kind, logic valid,
                                             logic permit);
        logic p;
        case (kind)
            KIND_NOSTALL: p = valid;
            KIND_RUNOFF:  p = permit;
            default:      p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pl_stage_ctrl.sv
// Stage controller for stages 1..N-1: holds the one-bit enable and the
// drain permit, and forms the stage valid from its kind. Assumes stall is
// synchronous to clk and prev_valid/prev_permit come from the stage before.
module pl_stage_ctrl
    import pl_pkg::*;
#(
    parameter stage_kind_e KIND = KIND_CONT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic prev_valid,
    input  logic prev_permit,
    output logic en,
    output logic valid,
    output logic permit_out
);

    logic en_q;
    logic permit_q;
    logic advance;

    // Decide when the enable register may take the upstream valid.
    always_comb begin
        case (KIND)
            KIND_STALL:  advance = ~stall;
            KIND_RUNOFF: advance = ~stall | prev_permit | valid;
            default:     advance = 1'b1;
        endcase
    end

    // Enable register: clears on reset, captures upstream valid on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (advance) en_q <= prev_valid;
    end

    // Permit register: follows the upstream permit every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) permit_q <= 1'b0;
        else        permit_q <= prev_permit;
    end

    // Stage outputs derived from the kind rules.
    always_comb begin
        en         = en_q;
        valid      = kind_valid(KIND, en_q, permit_q, stall);
        permit_out = kind_permit_out(KIND, valid, permit_q);
    end

    generate
        if (KIND == KIND_STALL) begin : g_stall_chk
            AST_STALL_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                stall |=> $stable(en_q)) else $error("enable moved under stall"); // R4
        end
        if (KIND == KIND_NOSTALL) begin : g_nostall_chk
            AST_NOSTALL_STALL_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
                (stall && en_q) |-> valid) else $error("non-stallable valid masked"); // R5
        end
    endgenerate

endmodule

// File: rtl/pl_stage_data.sv
// Stage datapath: adds the stage constant to the incoming word and
// registers the sum. Assumes load is the stage valid; when ALWAYS_LOAD is
// set (fully continuous pipeline) the register loads every clock.
module pl_stage_data #(
    parameter int               DATA_W      = 8,
    parameter logic [DATA_W-1:0] STEP       = '0,
    parameter bit               ALWAYS_LOAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] sum;
    logic              do_load;

    // Placeholder stage function and load decision.
    assign sum     = din + STEP;
    assign do_load = ALWAYS_LOAD ? 1'b1 : load;

    // Data register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (do_load) q <= sum;
    end

    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din) + STEP)) else $error("stage data not captured"); // R8
    generate
        if (!ALWAYS_LOAD) begin : g_hold_chk
            AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> $stable(q)) else $error("stage data moved while idle"); // R8
        end
    endgenerate

endmodule

// File: rtl/pl_mixed_pipe.sv
// Top: linear pipeline of NUM_STAGES stages with per-stage kinds taken from
// STAGE_KINDS (2 bits per stage, stage 0 in the low bits). Stage 0 is
// enabled by go; stages 0..N-2 end in a data register; the last stage drives
// the result combinationally. Assumes 2 <= NUM_STAGES <= pl_pkg::MAX_STAGES.
module pl_mixed_pipe
    import pl_pkg::*;
#(
    parameter int                NUM_STAGES  = 5,
    parameter int                DATA_W      = 8,
    parameter logic [KVEC_W-1:0] STAGE_KINDS = 16'h03DA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stall,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              out_valid
);

    localparam bit          ALL_CONT  = all_continuous(STAGE_KINDS, NUM_STAGES);
    localparam stage_kind_e HEAD_KIND = kind_at(STAGE_KINDS, 0);
    localparam logic [DATA_W-1:0] LAST_STEP = DATA_W'(NUM_STAGES);

    logic [NUM_STAGES-1:0] st_en;
    logic [NUM_STAGES-1:0] st_valid;
    logic [NUM_STAGES-1:0] st_permit;
    logic [DATA_W-1:0]     dreg [NUM_STAGES-1];

    // Stage 0 control: enable is go, no permit arrives from upstream.
    always_comb begin
        st_en[0]     = go;
        st_valid[0]  = kind_valid(HEAD_KIND, go, 1'b0, stall);
        st_permit[0] = kind_permit_out(HEAD_KIND, st_valid[0], 1'b0);
    end

    generate
        for (genvar i = 1; i < NUM_STAGES; i++) begin : g_ctrl
            localparam stage_kind_e KI = kind_at(STAGE_KINDS, i);

            pl_stage_ctrl #(.KIND(KI)) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .stall      (stall),
                .prev_valid (st_valid[i-1]),
                .prev_permit(st_permit[i-1]),
                .en         (st_en[i]),
                .valid      (st_valid[i]),
                .permit_out (st_permit[i])
            );

            if (KI == KIND_NOSTALL) begin : g_ns_chk
                AST_NOSTALL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (st_en[i] == $past(st_valid[i-1])))
                    else $error("non-stallable enable missed upstream valid"); // R5
            end
            if (KI == KIND_RUNOFF) begin : g_ro_chk
                AST_RUNOFF_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_valid[i-1] && st_permit[i-1]) |=> st_en[i])
                    else $error("runoff stage refused a permitted token"); // R6
                AST_RUNOFF_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_valid[i] && !st_valid[i-1]) |=> !st_en[i])
                    else $error("runoff token kept after issue"); // R7
            end
        end

        for (genvar i = 0; i < NUM_STAGES - 1; i++) begin : g_data
            localparam stage_kind_e KI = kind_at(STAGE_KINDS, i);
            logic [DATA_W-1:0] stage_in;

            if (i == 0) begin : g_src_in
                assign stage_in = data_in;
            end else begin : g_src_reg
                assign stage_in = dreg[i-1];
            end

            pl_stage_data #(
                .DATA_W     (DATA_W),
                .STEP       (DATA_W'(i + 1)),
                .ALWAYS_LOAD(ALL_CONT)
            ) u_data (
                .clk  (clk),
                .rst_n(rst_n),
                .load (st_valid[i]),
                .din  (stage_in),
                .q    (dreg[i])
            );

            if (KI == KIND_STALL) begin : g_sd_chk
                AST_STALL_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    stall |=> $stable(dreg[i]))
                    else $error("stallable data moved under stall"); // R4
            end
        end
    endgenerate

    // Last stage: combinational result and valid.
    always_comb begin
        data_out  = dreg[NUM_STAGES-2] + LAST_STEP;
        out_valid = st_valid[NUM_STAGES-1];
    end

    AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> st_en[NUM_STAGES-1]) else $error("output valid without enable"); // R9

endmodule

// File: tb/pl_mixed_pipe_tb.sv
`timescale 1ns/1ps

// Bench-side cycle model of the pipeline, written from the requirements.
module pl_ref_model #(
    parameter int          N     = 5,
    parameter int          W     = 8,
    parameter logic [15:0] KINDS = 16'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         stall,
    input  logic [W-1:0] din,
    output logic [W-1:0] exp_data,
    output logic         exp_valid
);
    logic         en  [8];
    logic         per [8];
    logic [W-1:0] d   [8];
    logic         v   [8];
    logic         po  [8];
    logic [W-1:0] x   [8];
    bit           allc;

    function automatic int kind_of(int i);
        return int'(KINDS[2*i +: 2]);
    endfunction

    function automatic logic f_valid(int k, logic e, logic p, logic s);
        if (k == 2) return e & ~s;          // stallable
        if (k == 3) return e & (p | ~s);    // runoff
        return e;                           // continuous, non-stallable
    endfunction

    function automatic logic f_permit(int k, logic val, logic p);
        if (k == 1) return val;
        if (k == 3) return p;
        return 1'b0;
    endfunction

    always_comb begin
        allc = 1'b1;
        for (int i = 0; i < N; i++) if (kind_of(i) != 0) allc = 1'b0;
        for (int i = 0; i < 8; i++) begin
            v[i] = 1'b0; po[i] = 1'b0; x[i] = '0;
        end
        for (int i = 0; i < N; i++) begin
            v[i]  = f_valid(kind_of(i), (i == 0) ? go : en[i], (i == 0) ? 1'b0 : per[i], stall);
            po[i] = f_permit(kind_of(i), v[i], (i == 0) ? 1'b0 : per[i]);
            x[i]  = ((i == 0) ? din : d[i-1]) + W'(i + 1);
        end
        exp_data  = x[N-1];
        exp_valid = v[N-1];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                en[i] <= 1'b0; per[i] <= 1'b0; d[i] <= '0;
            end
        end else begin
            for (int i = 1; i < N; i++) begin
                per[i] <= po[i-1];
                if (kind_of(i) == 2) begin
                    if (!stall) en[i] <= v[i-1];
                end else if (kind_of(i) == 3) begin
                    if (!stall || po[i-1] || v[i]) en[i] <= v[i-1];
                end else begin
                    en[i] <= v[i-1];
                end
            end
            for (int i = 0; i < N - 1; i++) if (allc || v[i]) d[i] <= x[i];
        end
    end
endmodule

module pl_mixed_pipe_tb;
    localparam int          W         = 8;
    localparam int          MIX_N     = 5;
    localparam logic [15:0] MIX_KINDS = 16'h03DA; // stall, stall, nostall, runoff, runoff
    localparam int          CON_N     = 3;
    localparam logic [15:0] CON_KINDS = 16'h0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic         stall = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] mix_out, con_out, mix_exp, con_exp;
    logic         mix_v, con_v, mix_ev, con_ev;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    pl_mixed_pipe #(.NUM_STAGES(MIX_N), .DATA_W(W), .STAGE_KINDS(MIX_KINDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .stall(stall), .data_in(data_in),
        .data_out(mix_out), .out_valid(mix_v));
    pl_mixed_pipe #(.NUM_STAGES(CON_N), .DATA_W(W), .STAGE_KINDS(CON_KINDS)) u_cont (
        .clk(clk), .rst_n(rst_n), .go(go), .stall(stall), .data_in(data_in),
        .data_out(con_out), .out_valid(con_v));
    pl_ref_model #(.N(MIX_N), .W(W), .KINDS(MIX_KINDS)) u_ref_mix (
        .clk(clk), .rst_n(rst_n), .go(go), .stall(stall), .din(data_in),
        .exp_data(mix_exp), .exp_valid(mix_ev));
    pl_ref_model #(.N(CON_N), .W(W), .KINDS(CON_KINDS)) u_ref_con (
        .clk(clk), .rst_n(rst_n), .go(go), .stall(stall), .din(data_in),
        .exp_data(con_exp), .exp_valid(con_ev));

    task automatic check(string tag, string who, logic [W-1:0] ad, logic av,
                         logic [W-1:0] ed, logic ev, bit data_always);
        checks++;
        if (av !== ev || ((ev || data_always) && ad !== ed)) begin
            fails++;
            $display("FAIL %s %s: valid=%0b data=%02h expected valid=%0b data=%02h",
                     tag, who, av, ad, ev, ed);
        end
    endtask

    // Drive one cycle of inputs, compare after settle, move to next negedge.
    task automatic cycle(bit g, bit s, logic [W-1:0] d, string tag);
        go = g; stall = s; data_in = d;
        #1;
        check(tag, "mixed", mix_out, mix_v, mix_exp, mix_ev, 1'b0);
        check({tag, " R8"}, "continuous", con_out, con_v, con_exp, con_ev, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20517));
        repeat (2) @(negedge clk);
        // R1: reset state, go held high during reset
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 8'h11, "R1");
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 8'h00, "R1");
        // R2 R3: single token, latency and added constants
        cycle(1'b1, 1'b0, 8'hF0, "R2 R3");
        for (int k = 0; k < 6; k++) cycle(1'b0, 1'b0, 8'h00, "R2 R3");
        // R4 R6 R7 R10: burst then long stall with go held, then release
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, W'(8'h20 + k), "R4 R6");
        for (int k = 0; k < 12; k++) cycle(1'b1, 1'b1, W'(8'h40 + k), "R4 R6 R7 R10");
        for (int k = 0; k < 8; k++) cycle(1'b0, 1'b0, 8'h00, "R7 R9");
        // R5: stall toggling every cycle with go always high
        for (int k = 0; k < 12; k++) cycle(1'b1, k[0], W'(k * 7), "R5 R9");
        // Random, sparse stalls
        for (int k = 0; k < 3000; k++)
            cycle(($urandom % 4) != 0, ($urandom % 4) == 0, W'($urandom), "R3 R5 R9");
        // Random, bursty stalls
        begin
            bit s = 1'b0;
            for (int k = 0; k < 3000; k++) begin
                if (($urandom % 8) == 0) s = ~s;
                cycle(($urandom % 3) != 0, s, W'($urandom), "R4 R6 R7 R10");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule